// File: doc/BRIEF.md
# Single-Cycle Integer Core

This block is a 32-bit processor core that completes one instruction per clock. It fetches the word at the program counter from an instruction port, decodes it, reads two source registers, runs the arithmetic unit and either writes a register, reads data memory into a register, writes data memory, or redirects the program counter. All of this happens within one cycle. The supported operations are add, subtract, bitwise and, bitwise or, signed set-on-less-than, word load, word store, branch-if-equal and absolute jump. Exceptions, stalls and memory wait states are not supported.

Decoding is done in two levels. A primary decoder turns the opcode into datapath selects, enables and a two-bit arithmetic class. A secondary decoder combines that class with the function field to give a three-bit arithmetic control code. The top bit of that code complements the second operand and supplies the adder carry-in. Both memories are outside the block and are read combinationally. Register file and data memory writes take effect on the rising edge only when their enable is high.

Top module: `scalar_core`

## Requirements
- R1: A synchronous active-high reset sets the program counter, seen on `imem_addr`, to 0.
- R2: A non-control-flow instruction advances the program counter by 4 at the next edge.
- R3: Register-format instructions (opcode 0x00) use the function field: 0x20 add, 0x22 subtract, 0x24 and, 0x25 or. The result is written to the rd field register (bits 15:11).
- R4: Register-format function 0x2A writes 1 when rs is less than rt as signed values, and 0 otherwise. The subtract sign is corrected for overflow.
- R5: Load (opcode 0x23) drives `dmem_addr` with rs plus the sign-extended 16-bit immediate, asserts `dmem_re`, and writes `dmem_rdata` into the rt field register (bits 20:16).
- R6: Store (opcode 0x2B) drives `dmem_addr` with rs plus the sign-extended immediate and `dmem_wdata` with rt, and asserts `dmem_we`. It writes no register.
- R7: Branch-if-equal (opcode 0x04) goes to PC+4 plus the sign-extended immediate times 4 when rs equals rt, and to PC+4 otherwise. Backward offsets are included.
- R8: Jump (opcode 0x02) goes to the upper 4 bits of PC+4, followed by the 26-bit target field, followed by two zero bits.
- R9: Register 0 always reads as zero, and writes to it are discarded.
- R10: `dmem_we` is high only for stores and `dmem_re` only for loads. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Program counter, byte address of the fetched word |
| imem_data | input | 32 | Instruction word at `imem_addr`, combinational |
| dmem_addr | output | 32 | Data memory byte address |
| dmem_wdata | output | 32 | Store data |
| dmem_rdata | input | 32 | Load data at `dmem_addr`, combinational |
| dmem_we | output | 1 | Data memory write enable, applied at the rising edge |
| dmem_re | output | 1 | Data memory read strobe |

## Verification
The only state in this block is the program counter and the register file. A wrong program counter shows up on `imem_addr` in the very next cycle. A wrong register value stays hidden until a later store puts it on `dmem_wdata`, or until a branch that compares it changes the fetch sequence. For this reason the test program stores every computed register right after it is produced, and checks the fetch address on every cycle. Each fault then becomes visible within a few instructions of its cause.

// File: rtl/core_pkg.sv
package core_pkg;

    localparam int XLEN   = 32;
    localparam int NREGS  = 32;
    localparam int RIDX_W = $clog2(NREGS);

    localparam logic [5:0] OP_RTYPE = 6'h00;
    localparam logic [5:0] OP_LOAD  = 6'h23;
    localparam logic [5:0] OP_STORE = 6'h2B;
    localparam logic [5:0] OP_BEQ   = 6'h04;
    localparam logic [5:0] OP_JUMP  = 6'h02;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [1:0] {
        CLS_ADD   = 2'b00,
        CLS_SUB   = 2'b01,
        CLS_FUNCT = 2'b10
    } alu_class_e;

    typedef enum logic [2:0] {
        ACT_AND = 3'b000,
        ACT_OR  = 3'b001,
        ACT_ADD = 3'b010,
        ACT_SUB = 3'b110,
        ACT_SLT = 3'b111
    } alu_ctl_e;

    typedef struct packed {
        logic       dst_rd;
        logic       src_imm;
        logic       wb_mem;
        logic       reg_we;
        logic       mem_re;
        logic       mem_we;
        logic       is_branch;
        logic       is_jump;
        alu_class_e alu_class;
    } ctrl_t;

    function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
        return {{(XLEN-16){v[15]}}, v};
    endfunction

endpackage

// File: rtl/core_main_dec.sv
module core_main_dec
    import core_pkg::*;
(
    input  logic [5:0] opcode,
    output ctrl_t      ctrl
);
    always_comb begin
        ctrl = '0;
        ctrl.alu_class = CLS_ADD;
        unique case (opcode)
            OP_RTYPE: begin
                ctrl.dst_rd    = 1'b1;
                ctrl.reg_we    = 1'b1;
                ctrl.alu_class = CLS_FUNCT;
            end
            OP_LOAD: begin
                ctrl.src_imm = 1'b1;
                ctrl.wb_mem  = 1'b1;
                ctrl.reg_we  = 1'b1;
                ctrl.mem_re  = 1'b1;
            end
            OP_STORE: begin
                ctrl.src_imm = 1'b1;
                ctrl.mem_we  = 1'b1;
            end
            OP_BEQ: begin
                ctrl.is_branch = 1'b1;
                ctrl.alu_class = CLS_SUB;
            end
            OP_JUMP: begin
                ctrl.is_jump = 1'b1;
            end
            default: ctrl = '0;
        endcase
    end
endmodule

// File: rtl/core_alu_dec.sv
module core_alu_dec
    import core_pkg::*;
(
    input  alu_class_e cls,
    input  logic [5:0] funct,
    output alu_ctl_e   ctl
);
    always_comb begin
        ctl = ACT_ADD;
        case (cls)
            CLS_ADD: ctl = ACT_ADD;
            CLS_SUB: ctl = ACT_SUB;
            CLS_FUNCT: begin
                case (funct)
                    FN_ADD:  ctl = ACT_ADD;
                    FN_SUB:  ctl = ACT_SUB;
                    FN_AND:  ctl = ACT_AND;
                    FN_OR:   ctl = ACT_OR;
                    FN_SLT:  ctl = ACT_SLT;
                    default: ctl = ACT_ADD;
                endcase
            end
            default: ctl = ACT_ADD;
        endcase
    end
endmodule

// File: rtl/core_alu.sv
module core_alu
    import core_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_ctl_e     ctl,
    output logic [W-1:0] y,
    output logic         zero
);
    logic [2:0]   c;
    logic [W-1:0] b_eff;
    logic [W-1:0] sum;
    logic         ovf;

    always_comb begin
        c     = ctl;
        b_eff = c[2] ? ~b : b;
        sum   = a + b_eff + {{(W-1){1'b0}}, c[2]};
        ovf   = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
        case (c[1:0])
            2'b00:   y = a & b_eff;
            2'b01:   y = a | b_eff;
            2'b10:   y = sum;
            default: y = {{(W-1){1'b0}}, sum[W-1] ^ ovf};
        endcase
        zero = (y == '0);
    end
endmodule

// File: rtl/core_regfile.sv
module core_regfile
    import core_pkg::*;
#(
    parameter int N  = NREGS,
    parameter int W  = XLEN,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ra_a,
    input  logic [AW-1:0] ra_b,
    output logic [W-1:0]  rd_a,
    output logic [W-1:0]  rd_b,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);
    logic [W-1:0] regs_q [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) regs_q[i] <= '0;
        end else if (we && (wa != '0)) begin
            regs_q[wa] <= wd;
        end
    end

    assign rd_a = regs_q[ra_a];
    assign rd_b = regs_q[ra_b];

    // R9
    zero_reg_chk: assert property (@(posedge clk) disable iff (rst)
        regs_q[0] == '0);
endmodule

// File: rtl/scalar_core.sv
module scalar_core
    import core_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    output logic [31:0] imem_addr,
    input  logic [31:0] imem_data,
    output logic [31:0] dmem_addr,
    output logic [31:0] dmem_wdata,
    input  logic [31:0] dmem_rdata,
    output logic        dmem_we,
    output logic        dmem_re
);
    logic [XLEN-1:0]   pc_q, pc_next, pc_plus4, br_tgt, jmp_tgt;
    logic [XLEN-1:0]   rs_val, rt_val, imm_ext, alu_b, alu_y, wb_data;
    logic [RIDX_W-1:0] rs_idx, rt_idx, rd_idx, wr_idx;
    logic              alu_zero, take_br;
    ctrl_t             ctrl;
    alu_ctl_e          alu_ctl;

    assign rs_idx  = imem_data[25:21];
    assign rt_idx  = imem_data[20:16];
    assign rd_idx  = imem_data[15:11];
    assign imm_ext = sext16(imem_data[15:0]);

    core_main_dec u_main (.opcode(imem_data[31:26]), .ctrl(ctrl));
    core_alu_dec  u_adec (.cls(ctrl.alu_class), .funct(imem_data[5:0]), .ctl(alu_ctl));

    core_regfile u_rf (
        .clk(clk), .rst(rst),
        .ra_a(rs_idx), .ra_b(rt_idx),
        .rd_a(rs_val), .rd_b(rt_val),
        .we(ctrl.reg_we), .wa(wr_idx), .wd(wb_data)
    );

    assign alu_b = ctrl.src_imm ? imm_ext : rt_val;

    core_alu u_alu (.a(rs_val), .b(alu_b), .ctl(alu_ctl), .y(alu_y), .zero(alu_zero));

    assign wr_idx  = ctrl.dst_rd ? rd_idx : rt_idx;
    assign wb_data = ctrl.wb_mem ? dmem_rdata : alu_y;

    assign pc_plus4 = pc_q + 32'd4;
    assign br_tgt   = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};
    assign jmp_tgt  = {pc_plus4[31:28], imem_data[25:0], 2'b00};
    assign take_br  = ctrl.is_branch & alu_zero;

    always_comb begin
        if (ctrl.is_jump)  pc_next = jmp_tgt;
        else if (take_br)  pc_next = br_tgt;
        else               pc_next = pc_plus4;
    end

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_next;
    end

    assign imem_addr  = pc_q;
    assign dmem_addr  = alu_y;
    assign dmem_wdata = rt_val;
    assign dmem_we    = ctrl.mem_we;
    assign dmem_re    = ctrl.mem_re;

    // R2
    seq_pc_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.is_jump && !take_br) |=> (pc_q == $past(pc_q) + 32'd4));

    // R7
    branch_pc_chk: assert property (@(posedge clk) disable iff (rst)
        take_br |=> (pc_q == $past(br_tgt)));

    // R8
    jump_pc_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl.is_jump |=> (pc_q[1:0] == 2'b00 && pc_q[31:28] == $past(pc_plus4[31:28])));

    // R6
    store_no_wb_chk: assert property (@(posedge clk) disable iff (rst)
        dmem_we |-> !ctrl.reg_we);

    // R10
    mem_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(dmem_we && dmem_re));
endmodule

// File: tb/test_scalar_core.sv
module test_scalar_core;
    localparam time CLK_PERIOD = 10ns;

    typedef struct {
        logic [31:0] pc;
        int          kind;   // 0 none, 1 store, 2 load
        logic [31:0] addr;
        logic [31:0] data;
        string       req;
    } step_t;

    logic        clk = 0;
    logic        rst = 1;
    logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we, dmem_re;

    logic [31:0] imem [128];
    logic [31:0] dmem [32];

    step_t exp_q[$];
    int    checks = 0;
    int    errors = 0;
    bit    started = 0;
    bit    mon_done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign imem_data  = imem[imem_addr[8:2]];
    assign dmem_rdata = dmem[dmem_addr[6:2]];

    always @(posedge clk) if (dmem_we) dmem[dmem_addr[6:2]] <= dmem_wdata;

    scalar_core i_scalar_core (
        .clk(clk), .rst(rst),
        .imem_addr(imem_addr), .imem_data(imem_data),
        .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata),
        .dmem_we(dmem_we), .dmem_re(dmem_re)
    );

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
        return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
    endfunction
    function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
        return {op, rs[4:0], rt[4:0], imm};
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic drive_step(logic [31:0] pc, int kind, logic [31:0] addr,
                              logic [31:0] data, string req);
        step_t s;
        s.pc = pc; s.kind = kind; s.addr = addr; s.data = data; s.req = req;
        exp_q.push_back(s);
    endtask

    // monitor: pops one expected item per cycle and compares the ports
    initial begin
        step_t s;
        wait (started);
        #1;
        while (exp_q.size() > 0) begin
            s = exp_q.pop_front();
            check(imem_addr == s.pc, {s.req, " pc"}, imem_addr, s.pc);
            check(dmem_we == (s.kind == 1), "R10 we", {31'd0, dmem_we}, {31'd0, s.kind == 1});
            check(dmem_re == (s.kind == 2), "R10 re", {31'd0, dmem_re}, {31'd0, s.kind == 2});
            if (s.kind != 0)
                check(dmem_addr == s.addr, {s.req, " addr"}, dmem_addr, s.addr);
            if (s.kind == 1)
                check(dmem_wdata == s.data, {s.req, " data"}, dmem_wdata, s.data);
            @(negedge clk);
            #1;
        end
        mon_done = 1;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 5000, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 128; i++) imem[i] = 32'd0;
        for (int i = 0; i < 32; i++)  dmem[i] = 32'd0;
        dmem[0] = 32'd5;
        dmem[1] = 32'd3;
        dmem[2] = 32'hFFFF_FFF0;
        dmem[3] = 32'h7FFF_FFFF;

        imem[0]  = enc_i(6'h23, 0, 1, 16'd0);       // lw r1
        imem[1]  = enc_i(6'h23, 0, 2, 16'd4);       // lw r2
        imem[2]  = enc_r(1, 2, 3, 6'h20);           // add
        imem[3]  = enc_r(1, 2, 4, 6'h22);           // sub
        imem[4]  = enc_r(1, 2, 5, 6'h24);           // and
        imem[5]  = enc_r(1, 2, 6, 6'h25);           // or
        imem[6]  = enc_r(2, 1, 7, 6'h2A);           // slt 3<5
        imem[7]  = enc_r(1, 2, 8, 6'h2A);           // slt 5<3
        imem[8]  = enc_i(6'h2B, 0, 3, 16'd16);
        imem[9]  = enc_i(6'h2B, 0, 4, 16'd20);
        imem[10] = enc_i(6'h2B, 0, 5, 16'd24);
        imem[11] = enc_i(6'h2B, 0, 6, 16'd28);
        imem[12] = enc_i(6'h2B, 0, 7, 16'd32);
        imem[13] = enc_i(6'h2B, 0, 8, 16'd36);
        imem[14] = enc_i(6'h23, 0, 9, 16'd8);
        imem[15] = enc_i(6'h23, 0, 10, 16'd12);
        imem[16] = enc_r(9, 10, 11, 6'h2A);         // slt with overflow
        imem[17] = enc_r(1, 1, 0, 6'h20);           // write to r0
        imem[18] = enc_i(6'h2B, 0, 11, 16'd40);
        imem[19] = enc_i(6'h2B, 0, 0, 16'd44);
        imem[20] = enc_i(6'h04, 1, 2, 16'd5);       // not taken
        imem[21] = enc_i(6'h04, 1, 1, 16'd2);       // taken to 96
        imem[22] = enc_i(6'h2B, 0, 1, 16'd48);
        imem[23] = enc_i(6'h2B, 0, 1, 16'd52);
        imem[24] = {6'h02, 26'h40};                 // jump to 256
        imem[25] = enc_i(6'h2B, 0, 1, 16'd52);
        imem[64] = enc_i(6'h2B, 0, 2, 16'd56);
        imem[65] = enc_i(6'h04, 0, 0, 16'hFFFF);    // self loop

        drive_step(0,  2, 0,  0, "R5");
        drive_step(4,  2, 4,  0, "R5");
        for (int a = 8; a <= 28; a += 4) drive_step(a, 0, 0, 0, "R2");
        drive_step(32, 1, 16, 8, "R3 add");
        drive_step(36, 1, 20, 2, "R3 sub");
        drive_step(40, 1, 24, 1, "R3 and");
        drive_step(44, 1, 28, 7, "R3 or");
        drive_step(48, 1, 32, 1, "R4 true");
        drive_step(52, 1, 36, 0, "R4 false");
        drive_step(56, 2, 8,  0, "R5");
        drive_step(60, 2, 12, 0, "R5");
        drive_step(64, 0, 0,  0, "R2");
        drive_step(68, 0, 0,  0, "R2");
        drive_step(72, 1, 40, 1, "R4 overflow");
        drive_step(76, 1, 44, 0, "R9");
        drive_step(80, 0, 0,  0, "R7 not taken");
        drive_step(84, 0, 0,  0, "R7 not taken");
        drive_step(96, 0, 0,  0, "R7 taken");
        drive_step(256, 1, 56, 3, "R8");
        for (int k = 0; k < 8; k++) drive_step(260, 0, 0, 0, "R7 backward");

        repeat (3) @(negedge clk);
        check(imem_addr == 32'd0, "R1 reset", imem_addr, 32'd0);
        rst = 0;
        started = 1;
        wait (mon_done);
        check(dmem[12] == 32'd0, "R6 skipped store", dmem[12], 32'd0);
        check(dmem[14] == 32'd3, "R6 memory", dmem[14], 32'd3);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule